// File: doc/BRIEF.md
# Cascadable Display Command and Data Receiver

This block is the serial front end of a segment-display driver that can be chained with several identical drivers behind one two-wire bus address. It oversamples the clock and data lines with the system clock, finds start and stop conditions, assembles bytes MSB first, and pulls the data line low during the acknowledge slot when the byte is meant for this device. After a matching write address it takes a run of command bytes, each of which presents a continuation flag in its top bit, and then switches to display data.

Every command byte is handed on through a one-cycle command strobe. Two command forms also act inside the block: one sets a display-memory pointer and one selects which chained device is addressed. Each data byte advances the pointer. When the pointer wraps, the device-select counter moves on, so a long data stream flows from one chained driver to the next. Only the device whose strap pins equal the device-select counter acknowledges a data byte and raises the memory write strobe. The other devices keep the same pointer state in step.

Top module: `disp_i2c_rx`

## Requirements
- R1: After reset the data-line drive (`sda_oe_o`) is released, and neither `cmd_valid_o` nor `wr_en_o` is asserted.
- R2: An address byte whose bits 7..2 are 011100, whose bit 1 equals `addr_sel_i` and whose bit 0 (R/W) is 0 is acknowledged by driving `sda_oe_o` high through the ninth clock pulse.
- R3: An address byte that differs from this pattern, including one with R/W = 1, is not acknowledged. All later bytes up to the next start condition get no acknowledge and produce no strobes.
- R4: Every byte in the command phase is acknowledged and is presented once on `cmd_byte_o` with a one-cycle `cmd_valid_o` pulse. A command with bit 7 = 1 keeps the block in the command phase.
- R5: A command byte with bit 7 = 0 is the last command. Every later byte of the transfer is display data, whatever its value.
- R6: A data byte is acknowledged, and `wr_en_o` is pulsed, only when `hw_sub_i` equals the device-select counter. Otherwise the line stays released and no write strobe appears.
- R7: A write strobe carries the received byte with the pointer and device-select counter values in effect before that byte. The pointer then increases by one after every data byte, whether or not this device was selected.
- R8: A data byte taken at the largest pointer value (63) sets the pointer to 0 and increases the device-select counter by one.
- R9: A command with bits 6..3 = 1110 loads bits 2..0 into the device-select counter. A command with bit 6 = 0 loads bits 5..0 into the pointer.
- R10: A stop condition ends the transfer, and later bytes are ignored until a start. A repeated start ends the transfer and begins a new address byte. Pointer and device-select counter keep their values across both.
- R11: `sda_oe_o` becomes asserted only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| addr_sel_i | input | 1 | Strap that picks bit 1 of the bus address |
| hw_sub_i | input | 3 | Strap pins giving this device's position in the chain |
| cmd_valid_o | output | 1 | One-cycle strobe for a received command byte |
| cmd_byte_o | output | 8 | Last received command byte |
| wr_en_o | output | 1 | One-cycle display-memory write strobe |
| wr_ptr_o | output | 6 | Memory pointer for the write |
| wr_sub_o | output | 3 | Device-select value for the write |
| wr_data_o | output | 8 | Display byte to store |

## Verification
The hardest case to reach is a pointer wrap in the middle of a data stream. At that point the device-select counter changes without any command, and acknowledge ownership passes to another device. The stimulus loads the pointer close to its top value with a command, sends data across the wrap with the strap pins held at the old device number to show the silent hand-off, and then moves the straps to the new number within the same transfer. A repeated start then checks that the counter held its value.

// File: rtl/disp_i2c_pkg.sv
// Shared definitions for the display bus receiver.
// Assumes: 8-bit bytes, MSB first, fixed 6-bit address prefix.
package disp_i2c_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_CMD  = 2'd2,
        PH_DATA = 2'd3
    } phase_t;

    localparam logic [5:0] ADDR_PREFIX = 6'b011100;
    localparam logic [3:0] SEL_OPCODE  = 4'b1110;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL/SDA into the system clock and derives edge and
// bus-condition pulses. Assumes the system clock is much faster than SCL.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic scl_lvl;
    logic scl_q;
    logic sda_q;

    // Synchronizer chains, idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
        end
    end

    assign scl_lvl = scl_sh[SYNC_STAGES-1];
    assign sda_lvl = sda_sh[SYNC_STAGES-1];

    // Previous-sample registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    // Edge and condition decode.
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_byte_rx.sv
// Bit counter and shift register for one byte plus its acknowledge slot.
// Pulses byte_done on the SCL fall after the last data bit, and slot_end
// on the SCL fall that closes the acknowledge slot.
module i2c_byte_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_done,
    output logic              slot_end
);

    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

    logic [CNT_W-1:0] bit_cnt;
    logic             bus_evt;

    assign bus_evt   = start_det | stop_det;
    assign byte_done = enable & ~bus_evt & scl_fall & (bit_cnt == CNT_LAST);
    assign slot_end  = enable & ~bus_evt & scl_fall & (bit_cnt == CNT_ACK);

    // Shift data bits on SCL rise and step through the acknowledge slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_byte <= '0;
        end else if (bus_evt) begin
            bit_cnt <= '0;
        end else if (enable) begin
            if (scl_rise && (bit_cnt < CNT_LAST)) begin
                rx_byte <= {rx_byte[BYTE_W-2:0], sda_lvl};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
                bit_cnt <= CNT_ACK;
            end else if (slot_end) begin
                bit_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/disp_ptr_ctrl.sv
// Display-memory pointer and chained-device select counter.
// Assumes load and advance never arrive in the same cycle.
module disp_ptr_ctrl #(
    parameter int PTR_W = 6,
    parameter int SUB_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_ptr,
    input  logic [PTR_W-1:0] ptr_val,
    input  logic             load_sub,
    input  logic [SUB_W-1:0] sub_val,
    input  logic             advance,
    output logic [PTR_W-1:0] ptr,
    output logic [SUB_W-1:0] sub
);

    localparam logic [PTR_W-1:0] PTR_MAX = '1;

    // Load from commands, or step after a data byte with carry into sub.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            sub <= '0;
        end else begin
            if (load_ptr) ptr <= ptr_val;
            if (load_sub) sub <= sub_val;
            if (advance) begin
                if (ptr == PTR_MAX) begin
                    ptr <= '0;
                    sub <= sub + 1'b1;
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/disp_i2c_rx.sv
// Top of the display bus receiver: address match, command/data phase
// sequencing, acknowledge drive and output strobes.
// Assumes an external open-drain pad: sda_oe_o = 1 pulls the line low.
module disp_i2c_rx
    import disp_i2c_pkg::*;
#(
    parameter int PTR_W = 6,
    parameter int SUB_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic             addr_sel_i,
    input  logic [SUB_W-1:0] hw_sub_i,
    output logic             cmd_valid_o,
    output logic [7:0]       cmd_byte_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [SUB_W-1:0] wr_sub_o,
    output logic [7:0]       wr_data_o
);

    localparam int BYTE_W = 8;

    logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_done, slot_end;
    phase_t            phase;
    logic [PTR_W-1:0]  cur_ptr;
    logic [SUB_W-1:0]  cur_sub;
    logic              addr_hit, dev_sel, cmd_take, data_take;
    logic              load_ptr, load_sub, give_ack;

    i2c_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_byte_rx #(.BYTE_W(BYTE_W)) u_byte (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (phase != PH_IDLE),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .rx_byte   (rx_byte),
        .byte_done (byte_done),
        .slot_end  (slot_end)
    );

    // Byte classification for the current phase.
    assign addr_hit  = (rx_byte[7:2] == ADDR_PREFIX) && (rx_byte[1] == addr_sel_i) && !rx_byte[0];
    assign dev_sel   = (hw_sub_i == cur_sub);
    assign cmd_take  = byte_done && (phase == PH_CMD);
    assign data_take = byte_done && (phase == PH_DATA);
    assign load_ptr  = cmd_take && !rx_byte[6];
    assign load_sub  = cmd_take && (rx_byte[6:3] == SEL_OPCODE);
    assign give_ack  = ((phase == PH_ADDR) && addr_hit) || (phase == PH_CMD) ||
                       ((phase == PH_DATA) && dev_sel);

    disp_ptr_ctrl #(.PTR_W(PTR_W), .SUB_W(SUB_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_ptr (load_ptr),
        .ptr_val  (rx_byte[PTR_W-1:0]),
        .load_sub (load_sub),
        .sub_val  (rx_byte[SUB_W-1:0]),
        .advance  (data_take),
        .ptr      (cur_ptr),
        .sub      (cur_sub)
    );

    // Transfer phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else if (start_det) begin
            phase <= PH_ADDR;
        end else if (stop_det) begin
            phase <= PH_IDLE;
        end else if (byte_done) begin
            case (phase)
                PH_ADDR: phase <= addr_hit ? PH_CMD : PH_IDLE;
                PH_CMD:  phase <= rx_byte[7] ? PH_CMD : PH_DATA;
                default: phase <= phase;
            endcase
        end
    end

    // Acknowledge drive across the ninth clock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_oe_o <= 1'b0;
        end else if (start_det || stop_det || slot_end) begin
            sda_oe_o <= 1'b0;
        end else if (byte_done) begin
            sda_oe_o <= give_ack;
        end
    end

    // Command strobe and captured byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid_o <= 1'b0;
            cmd_byte_o  <= '0;
        end else begin
            cmd_valid_o <= cmd_take;
            if (cmd_take) cmd_byte_o <= rx_byte;
        end
    end

    // Display-memory write strobe with pre-increment address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_ptr_o  <= '0;
            wr_sub_o  <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= data_take && dev_sel;
            if (data_take && dev_sel) begin
                wr_ptr_o  <= cur_ptr;
                wr_sub_o  <= cur_sub;
                wr_data_o <= rx_byte;
            end
        end
    end

endmodule

// File: rtl/disp_i2c_rx_chk.sv
// Property checker for disp_i2c_rx, attached by bind below.
module disp_i2c_rx_chk
    import disp_i2c_pkg::*;
#(
    parameter int PTR_W = 6,
    parameter int SUB_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             cmd_valid,
    input logic             wr_en,
    input phase_t           phase,
    input logic             scl_lvl,
    input logic             advance,
    input logic [PTR_W-1:0] ptr,
    input logic [SUB_W-1:0] sub
);

    localparam logic [PTR_W-1:0] PTR_MAX = '1;

    // R11: acknowledge drive starts only while the clock line is low
    p_ack_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_lvl));

    // R3: an ignored transfer never holds the line
    p_idle_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_oe);

    // R4: command strobes only follow the command phase
    p_cmd_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (phase == PH_CMD || phase == PH_DATA));

    // R6: a write is always acknowledged
    p_wr_acked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (sda_oe && phase == PH_DATA));

    // R7: pointer steps by one inside a device
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(advance) && $past(ptr) != PTR_MAX) |->
        (ptr == PTR_W'($past(ptr) + 1'b1) && sub == $past(sub)));

    // R8: wrap moves on to the next chained device
    p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(advance) && $past(ptr) == PTR_MAX) |->
        (ptr == '0 && sub == SUB_W'($past(sub) + 1'b1)));

    // R4: both strobes never coincide
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && wr_en));

endmodule

bind disp_i2c_rx disp_i2c_rx_chk #(.PTR_W(PTR_W), .SUB_W(SUB_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe_o),
    .cmd_valid (cmd_valid_o),
    .wr_en     (wr_en_o),
    .phase     (phase),
    .scl_lvl   (u_sync.scl_lvl),
    .advance   (data_take),
    .ptr       (cur_ptr),
    .sub       (cur_sub)
);

// File: tb/disp_i2c_rx_tb.sv
module disp_i2c_rx_tb;

    localparam int H = 10;

    typedef struct {
        bit         is_wr;
        logic [7:0] data;
        logic [5:0] ptr;
        logic [2:0] sub;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic msda = 1'b1;
    logic addr_sel = 1'b0;
    logic [2:0] hw_sub = 3'd0;
    logic sda_oe, cmd_valid, wr_en;
    logic [7:0] cmd_byte, wr_data;
    logic [5:0] wr_ptr;
    logic [2:0] wr_sub;
    wire sda_line = msda & ~sda_oe;

    int n_checks = 0;
    int n_fail = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    disp_i2c_rx u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .hw_sub_i(hw_sub),
        .cmd_valid_o(cmd_valid), .cmd_byte_o(cmd_byte),
        .wr_en_o(wr_en), .wr_ptr_o(wr_ptr), .wr_sub_o(wr_sub), .wr_data_o(wr_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        msda = 1'b1; wait_n(H);
        scl = 1'b1;  wait_n(H);
        msda = 1'b0; wait_n(H);
        scl = 1'b0;  wait_n(2);
    endtask

    task automatic i2c_stop();
        msda = 1'b0; wait_n(H);
        scl = 1'b1;  wait_n(H);
        msda = 1'b1; wait_n(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic got;
        for (int i = 7; i >= 0; i--) begin
            msda = b[i]; wait_n(H);
            scl = 1'b1;  wait_n(H);
            scl = 1'b0;  wait_n(2);
        end
        msda = 1'b1; wait_n(H);
        scl = 1'b1;  wait_n(H/2);
        got = (sda_line == 1'b0);
        check(got == exp_ack, req, 32'(got), 32'(exp_ack));
        wait_n(H/2);
        scl = 1'b0;  wait_n(2);
    endtask

    task automatic push_cmd(input logic [7:0] b, input string req);
        exp_t e;
        e.is_wr = 1'b0; e.data = b; e.ptr = '0; e.sub = '0; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic push_wr(input logic [5:0] p, input logic [2:0] s, input logic [7:0] d, input string req);
        exp_t e;
        e.is_wr = 1'b1; e.data = d; e.ptr = p; e.sub = s; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compare each strobe against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && (cmd_valid || wr_en)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R10 unexpected strobe", {cmd_valid, wr_en}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_wr)
                    check(wr_en && !cmd_valid && wr_data == e.data && wr_ptr == e.ptr && wr_sub == e.sub,
                          e.req, {wr_en, 7'd0, wr_sub, 5'd0, wr_ptr, wr_data},
                          {1'b1, 7'd0, e.sub, 5'd0, e.ptr, e.data});
                else
                    check(cmd_valid && !wr_en && cmd_byte == e.data, e.req,
                          {cmd_valid, 23'd0, cmd_byte}, {1'b1, 23'd0, e.data});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-R actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_n(5);
        // R1: reset state
        check(!sda_oe && !cmd_valid && !wr_en, "R1 reset outputs", {sda_oe, cmd_valid, wr_en}, 0);
        rst_n = 1'b1;
        wait_n(5);
        check(!sda_oe && !cmd_valid && !wr_en, "R1 after release", {sda_oe, cmd_valid, wr_en}, 0);

        // R2/R4/R9/R5/R7: basic write transfer
        i2c_start();
        send_byte(8'h70, 1'b1, "R2 address ack");
        push_cmd(8'h85, "R4 cmd strobe");
        send_byte(8'h85, 1'b1, "R4 cmd ack");              // R9 pointer := 5
        push_cmd(8'h70, "R5 last cmd strobe");
        send_byte(8'h70, 1'b1, "R5 last cmd ack");         // R9 select device 0
        push_wr(6'd5, 3'd0, 8'hA1, "R7 write ptr5");
        send_byte(8'hA1, 1'b1, "R6 data ack");
        push_wr(6'd6, 3'd0, 8'h85, "R5 cmd-like byte as data");
        send_byte(8'h85, 1'b1, "R5 data ack");
        i2c_stop();

        // R3: wrong select bit, then read bit
        i2c_start();
        send_byte(8'h72, 1'b0, "R3 wrong address no ack");
        send_byte(8'h85, 1'b0, "R3 ignored byte");
        i2c_stop();
        i2c_start();
        send_byte(8'h71, 1'b0, "R3 read no ack");
        send_byte(8'h00, 1'b0, "R3 ignored after read");
        i2c_stop();

        // R8: wrap at top of pointer range
        i2c_start();
        send_byte(8'h70, 1'b1, "R2 address ack 2");
        push_cmd(8'hBE, "R9 load ptr 62");
        send_byte(8'hBE, 1'b1, "R4 cmd ack 2");
        push_cmd(8'h70, "R9 select 0");
        send_byte(8'h70, 1'b1, "R4 cmd ack 3");
        push_wr(6'd62, 3'd0, 8'h11, "R7 write ptr62");
        send_byte(8'h11, 1'b1, "R6 ack ptr62");
        push_wr(6'd63, 3'd0, 8'h22, "R7 write ptr63");
        send_byte(8'h22, 1'b1, "R6 ack ptr63");
        send_byte(8'h33, 1'b0, "R8 wrapped to device 1 no ack");
        hw_sub = 3'd1;
        push_wr(6'd1, 3'd1, 8'h44, "R8 write on device 1");
        send_byte(8'h44, 1'b1, "R6 selected ack");

        // R10: repeated start, counters kept
        i2c_start();
        send_byte(8'h70, 1'b1, "R10 repeated start address");
        push_cmd(8'h03, "R10 cmd after restart");
        send_byte(8'h03, 1'b1, "R10 cmd ack");
        push_wr(6'd3, 3'd1, 8'h5A, "R10 sub kept");
        send_byte(8'h5A, 1'b1, "R10 data ack");
        hw_sub = 3'd2;
        send_byte(8'h6B, 1'b0, "R6 non-selected no ack");
        i2c_stop();

        // R10: bytes after stop are ignored
        send_byte(8'h70, 1'b0, "R10 after stop ignored");
        wait_n(20);
        check(exp_q.size() == 0, "R4/R7 all strobes seen", exp_q.size(), 0);

        // R2 with select strap high; R9 device select command
        addr_sel = 1'b1;
        hw_sub = 3'd5;
        i2c_start();
        send_byte(8'h72, 1'b1, "R2 address with select high");
        push_cmd(8'h75, "R9 select 5");
        send_byte(8'h75, 1'b1, "R9 cmd ack");
        push_wr(6'd5, 3'd5, 8'hC3, "R9 sub loaded 5");
        send_byte(8'hC3, 1'b1, "R9 data ack");
        i2c_stop();
        wait_n(20);
        check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule